// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer with Direction Predictor

This block is a direct-mapped table that the fetch stage consults with the current fetch address. In the same cycle it reports whether the address is a known branch, the target that branch took last time, and a taken or not-taken guess. Each entry keeps a tag, a target address and a two-bit direction state. When the address is not in the table, the guess comes from a fixed rule. The fetch stage supplies that rule with a flag that says whether the branch points backward. Backward branches are guessed taken and forward branches not taken.

The execute stage reports each resolved branch on a resolve port. The report carries the branch address, the real outcome and the real target. A report that finds its entry moves the direction state and refreshes the target. A taken report that does not find its entry creates one. A run-time mode pin selects how the two-bit state moves: a saturating up/down counter, or a hysteresis scheme. Both the lookup and the resolve port are single-cycle and always accepted, so neither carries a ready signal. A resolve is taken on every clock edge where its valid is high, and it can never be held back.

Top module: `btb_predictor`

## Requirements
- R1: After reset every lookup misses (`lk_hit` = 0) until a taken resolve has allocated an entry.
- R2: The index is address bits [7:2]. The tag is all remaining address bits, bits [31:8] and [1:0]. A lookup hits when the indexed entry is valid and its tag matches. On a hit, `lk_target` is the stored target and `lk_taken` is bit 1 of the stored state. With no write in between, the same address gives the same answer.
- R3: On a miss, `lk_target` is zero and `lk_taken` equals `lk_backward`.
- R4: A taken resolve that misses writes the entry with the resolve tag and target. Its state is weak-taken (2'b10), so a following lookup of that address hits and predicts taken.
- R5: A not-taken resolve that misses changes nothing, and a later lookup of that address still misses.
- R6: In saturating mode (`cnt_mode` = 0), the state steps by one toward the outcome and clamps at 2'b00 and 2'b11. The encoding is 00 strong-not-taken, 01 weak-not-taken, 10 weak-taken, 11 strong-taken.
- R7: In hysteresis mode (`cnt_mode` = 1), a wrong outcome in a weak state jumps to the strong state of the other direction. A wrong outcome in a strong state moves to the weak state of the same direction. A right outcome goes to the strong state of that direction.
- R8: In both modes, a single wrong outcome from a strong state does not change the predicted direction.
- R9: A taken resolve that misses because a different branch owns the same index replaces that entry. The displaced branch then misses.
- R10: When a lookup and a resolve touch the same index in one cycle, the lookup returns the contents from before the resolve.
- R11: A taken resolve that hits replaces the stored target. A not-taken resolve that hits keeps the stored target.
- R12: With `rs_valid` low, the resolve inputs have no effect on the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_mode | input | 1 | 0 saturating, 1 hysteresis |
| lk_pc | input | 32 | Fetch address to look up |
| lk_backward | input | 1 | Fetch-side flag: branch points backward |
| lk_hit | output | 1 | Address found in table |
| lk_target | output | 32 | Predicted target (zero on miss) |
| lk_taken | output | 1 | Predicted direction |
| rs_valid | input | 1 | Resolve report present this cycle |
| rs_pc | input | 32 | Address of the resolved branch |
| rs_taken | input | 1 | Real outcome |
| rs_target | input | 32 | Real target |

## Verification
The hardest state to reach from the ports is the one where a lookup and a resolve hit the same index in the same cycle while the resolve also changes the predicted direction. Several directed setup steps are needed to put the entry there. The stimulus first walks a counter to a weak state through resolves alone. It then issues the lookup together with the resolve that would flip the direction, and checks the old answer and then the new one. Aliasing is driven in a similar way: address pairs that differ only in tag are aimed at one index. A random phase then mixes a small pool of colliding addresses with mode changes. A behavioural model is compared against the outputs on every clock.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef logic [1:0] dir_state_t;

  localparam dir_state_t ST_STRONG_NT = 2'b00;
  localparam dir_state_t ST_WEAK_NT   = 2'b01;
  localparam dir_state_t ST_WEAK_T    = 2'b10;
  localparam dir_state_t ST_STRONG_T  = 2'b11;

  typedef enum logic {
    MODE_SATURATE = 1'b0,
    MODE_HYSTER   = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6,
  parameter int ALIGN = 2,
  localparam int TAG_W = PC_W - IDX_W
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);
  assign idx = pc[ALIGN +: IDX_W];

  generate
    if (ALIGN == 0) begin : g_no_low
      assign tag = pc[PC_W-1:IDX_W];
    end else begin : g_low
      assign tag = {pc[PC_W-1:ALIGN+IDX_W], pc[ALIGN-1:0]};
    end
  endgenerate
endmodule

// File: rtl/btb_dir_update.sv
module btb_dir_update
  import btb_pkg::*;
(
  input  dir_state_t cur,
  input  logic       taken,
  input  cnt_mode_e  mode,
  output dir_state_t nxt
);
  dir_state_t sat_nxt;
  dir_state_t hys_nxt;

  always_comb begin
    if (taken) sat_nxt = (cur == ST_STRONG_T)  ? ST_STRONG_T  : dir_state_t'(cur + 2'd1);
    else       sat_nxt = (cur == ST_STRONG_NT) ? ST_STRONG_NT : dir_state_t'(cur - 2'd1);
  end

  always_comb begin
    unique case (cur)
      ST_STRONG_NT: hys_nxt = taken ? ST_WEAK_NT  : ST_STRONG_NT;
      ST_WEAK_NT:   hys_nxt = taken ? ST_STRONG_T : ST_STRONG_NT;
      ST_WEAK_T:    hys_nxt = taken ? ST_STRONG_T : ST_STRONG_NT;
      default:      hys_nxt = taken ? ST_STRONG_T : ST_WEAK_T;
    endcase
  end

  assign nxt = (mode == MODE_HYSTER) ? hys_nxt : sat_nxt;

  always_comb begin
    if (mode == MODE_SATURATE) begin
      p_sat_step_r6: assert (taken ? (int'(nxt) >= int'(cur) && int'(nxt) - int'(cur) <= 1)
                                   : (int'(cur) >= int'(nxt) && int'(cur) - int'(nxt) <= 1))
        else $error("saturating step broken");
    end
    if (mode == MODE_HYSTER && (cur == ST_WEAK_NT || cur == ST_WEAK_T) && cur[1] != taken) begin
      p_hyst_jump_r7: assert (nxt == {taken, taken})
        else $error("hysteresis weak-state jump broken");
    end
    if ((cur == ST_STRONG_NT || cur == ST_STRONG_T)) begin
      p_two_miss_r8: assert (nxt[1] == cur[1])
        else $error("strong state flipped on one outcome");
    end
  end
endmodule

// File: rtl/btb_entry_array.sv
module btb_entry_array
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6,
  localparam int TAG_W = PC_W - IDX_W,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] a_idx,
  output logic             a_valid,
  output logic [TAG_W-1:0] a_tag,
  output logic [PC_W-1:0]  a_tgt,
  output dir_state_t       a_st,
  input  logic [IDX_W-1:0] b_idx,
  output logic             b_valid,
  output logic [TAG_W-1:0] b_tag,
  output logic [PC_W-1:0]  b_tgt,
  output dir_state_t       b_st,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_tgt,
  input  dir_state_t       wr_st
);
  logic [DEPTH-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [PC_W-1:0]  tgt_q [DEPTH];
  dir_state_t       st_q  [DEPTH];

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(e));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          valid_q[e] <= 1'b0;
          tag_q[e]   <= '0;
          tgt_q[e]   <= '0;
          st_q[e]    <= ST_STRONG_NT;
        end else if (sel) begin
          valid_q[e] <= 1'b1;
          tag_q[e]   <= wr_tag;
          tgt_q[e]   <= wr_tgt;
          st_q[e]    <= wr_st;
        end
      end
    end
  endgenerate

  assign a_valid = valid_q[a_idx];
  assign a_tag   = tag_q[a_idx];
  assign a_tgt   = tgt_q[a_idx];
  assign a_st    = st_q[a_idx];
  assign b_valid = valid_q[b_idx];
  assign b_tag   = tag_q[b_idx];
  assign b_tgt   = tgt_q[b_idx];
  assign b_st    = st_q[b_idx];

  p_valid_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(valid_q) >= $past($countones(valid_q)))
    else $error("valid entry lost");

  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)
               && st_q[$past(wr_idx)] == $past(wr_st)))
    else $error("entry write not stored");
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6,
  parameter int ALIGN = 2,
  localparam int TAG_W = PC_W - IDX_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cnt_mode,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            lk_backward,
  output logic            lk_hit,
  output logic [PC_W-1:0] lk_target,
  output logic            lk_taken,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken,
  input  logic [PC_W-1:0] rs_target
);
  logic [IDX_W-1:0] lk_idx, rs_idx;
  logic [TAG_W-1:0] lk_tag, rs_tag;
  logic             a_valid, b_valid;
  logic [TAG_W-1:0] a_tag, b_tag;
  logic [PC_W-1:0]  a_tgt, b_tgt;
  dir_state_t       a_st, b_st, upd_st, wr_st;
  logic             rs_hit, wr_en;
  logic [PC_W-1:0]  wr_tgt;

  btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN(ALIGN)) u_lk_split (
    .pc(lk_pc), .idx(lk_idx), .tag(lk_tag));
  btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN(ALIGN)) u_rs_split (
    .pc(rs_pc), .idx(rs_idx), .tag(rs_tag));

  btb_entry_array #(.PC_W(PC_W), .IDX_W(IDX_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .a_idx(lk_idx), .a_valid(a_valid), .a_tag(a_tag), .a_tgt(a_tgt), .a_st(a_st),
    .b_idx(rs_idx), .b_valid(b_valid), .b_tag(b_tag), .b_tgt(b_tgt), .b_st(b_st),
    .wr_en(wr_en), .wr_idx(rs_idx), .wr_tag(rs_tag), .wr_tgt(wr_tgt), .wr_st(wr_st));

  btb_dir_update u_dir (
    .cur(b_st), .taken(rs_taken), .mode(cnt_mode_e'(cnt_mode)), .nxt(upd_st));

  // lookup side: table answer or static backward-taken fallback
  assign lk_hit    = a_valid && (a_tag == lk_tag);
  assign lk_target = lk_hit ? a_tgt : '0;
  assign lk_taken  = lk_hit ? a_st[1] : lk_backward;

  // resolve side: update on hit, allocate on taken miss
  assign rs_hit = b_valid && (b_tag == rs_tag);
  assign wr_en  = rs_valid && (rs_hit || rs_taken);
  assign wr_st  = rs_hit ? upd_st : ST_WEAK_T;
  assign wr_tgt = rs_taken ? rs_target : b_tgt;

  p_miss_static_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_taken == lk_backward && lk_target == '0))
    else $error("miss did not use static rule");

  p_lookup_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && $stable(lk_pc) && $stable(lk_backward))
      |-> ($stable(lk_hit) && $stable(lk_target) && $stable(lk_taken)))
    else $error("lookup changed without a write");
endmodule

// File: tb/btb_predictor_test.sv
module btb_predictor_test;
  localparam int CLK_PERIOD = 10;
  localparam int NENT = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_mode = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        lk_backward = 1'b0;
  logic        lk_hit;
  logic [31:0] lk_target;
  logic        lk_taken;
  logic        rs_valid = 1'b0;
  logic [31:0] rs_pc = '0;
  logic        rs_taken = 1'b0;
  logic [31:0] rs_target = '0;

  int ntests = 0;
  int nfail  = 0;

  // behavioural model: full address kept per slot
  bit          m_valid [NENT];
  logic [31:0] m_pc    [NENT];
  logic [31:0] m_tgt   [NENT];
  int          m_ctr   [NENT];

  always #(CLK_PERIOD/2) clk = ~clk;

  btb_predictor uut (
    .clk(clk), .rst_n(rst_n), .cnt_mode(cnt_mode),
    .lk_pc(lk_pc), .lk_backward(lk_backward),
    .lk_hit(lk_hit), .lk_target(lk_target), .lk_taken(lk_taken),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken), .rs_target(rs_target));

  function automatic int slot(input logic [31:0] pc);
    return int'((pc >> 2) & 32'h3f);
  endfunction

  function automatic int next_ctr(input int c, input bit t, input bit hyst);
    bit pred;
    if (!hyst) return t ? ((c < 3) ? c + 1 : 3) : ((c > 0) ? c - 1 : 0);
    pred = (c >= 2);
    if (pred == t) return t ? 3 : 0;
    if (c == 0 || c == 3) return t ? 1 : 2;
    return t ? 3 : 0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare, advance model across the posedge
  task automatic step(input logic [31:0] lpc, input bit lback, input bit rv,
                      input logic [31:0] rpc, input bit rt, input logic [31:0] rtg,
                      input bit md, input string req);
    int s, r;
    bit ehit, etk;
    logic [31:0] etgt;
    lk_pc = lpc; lk_backward = lback; rs_valid = rv; rs_pc = rpc;
    rs_taken = rt; rs_target = rtg; cnt_mode = md;
    #1;
    s = slot(lpc);
    ehit = m_valid[s] && (m_pc[s] == lpc);
    etgt = ehit ? m_tgt[s] : 32'h0;
    etk  = ehit ? (m_ctr[s] >= 2) : lback;
    chk(lk_hit == ehit, req, "hit", 32'(lk_hit), 32'(ehit));
    chk(lk_target == etgt, req, "target", lk_target, etgt);
    chk(lk_taken == etk, req, "taken", 32'(lk_taken), 32'(etk));
    if (rv) begin
      r = slot(rpc);
      if (m_valid[r] && m_pc[r] == rpc) begin
        m_ctr[r] = next_ctr(m_ctr[r], rt, md);
        if (rt) m_tgt[r] = rtg;
      end else if (rt) begin
        m_valid[r] = 1'b1; m_pc[r] = rpc; m_tgt[r] = rtg; m_ctr[r] = 2;
      end
    end
    @(negedge clk);
  endtask

  task automatic look(input logic [31:0] pc, input bit back, input bit md, input string req);
    step(pc, back, 1'b0, 32'h0, 1'b0, 32'h0, md, req);
  endtask

  task automatic res(input logic [31:0] pc, input bit t, input logic [31:0] tg,
                     input bit md, input string req);
    step(32'hffff_fff0, 1'b0, 1'b1, pc, t, tg, md, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    logic [31:0] pa, pb, pc2, pd;
    for (int i = 0; i < NENT; i++) begin
      m_valid[i] = 0; m_pc[i] = '0; m_tgt[i] = '0; m_ctr[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    pa  = 32'h0000_1040;
    pb  = 32'h0000_2080;
    pc2 = 32'h0001_1040;   // same slot as pa, other tag
    pd  = 32'h0000_30c0;

    // R1: empty after reset; R3 static fallback both directions
    look(pa, 1'b0, 1'b0, "R1");
    look(pa, 1'b1, 1'b0, "R1");
    look(pb, 1'b1, 1'b0, "R3");
    look(pd, 1'b0, 1'b0, "R3");

    // R12: resolve inputs ignored while rs_valid low
    step(pd, 1'b0, 1'b0, pa, 1'b1, 32'h0000_0400, 1'b0, "R12");
    look(pa, 1'b0, 1'b0, "R12");

    // R5: not-taken miss does not allocate
    res(pa, 1'b0, 32'h0000_0500, 1'b0, "R5");
    look(pa, 1'b0, 1'b0, "R5");

    // R4: taken miss allocates weak-taken
    res(pa, 1'b1, 32'h0000_0500, 1'b0, "R4");
    look(pa, 1'b0, 1'b0, "R4");

    // R6 saturating walk from weak-taken
    res(pa, 1'b0, 32'h0, 1'b0, "R6");  // 10->01
    look(pa, 1'b1, 1'b0, "R6");
    res(pa, 1'b0, 32'h0, 1'b0, "R6");  // 01->00
    res(pa, 1'b0, 32'h0, 1'b0, "R6");  // clamp
    res(pa, 1'b1, 32'h0000_0600, 1'b0, "R6");  // 00->01
    look(pa, 1'b1, 1'b0, "R6");
    res(pa, 1'b1, 32'h0000_0600, 1'b0, "R6");  // 01->10
    res(pa, 1'b1, 32'h0000_0600, 1'b0, "R6");  // 10->11
    res(pa, 1'b1, 32'h0000_0600, 1'b0, "R6");  // clamp
    // R8: one wrong outcome from strong keeps direction (saturating)
    res(pa, 1'b0, 32'h0, 1'b0, "R8");
    look(pa, 1'b0, 1'b0, "R8");

    // R11: not-taken hit keeps target, taken hit replaces it
    look(pa, 1'b0, 1'b0, "R11");
    res(pa, 1'b1, 32'h0000_0a00, 1'b0, "R11");
    look(pa, 1'b0, 1'b0, "R11");

    // R7 hysteresis walk on pb
    res(pb, 1'b1, 32'h0000_0700, 1'b1, "R7");  // alloc 10
    res(pb, 1'b0, 32'h0, 1'b1, "R7");          // 10->00
    look(pb, 1'b1, 1'b1, "R7");
    res(pb, 1'b1, 32'h0000_0700, 1'b1, "R7");  // 00->01
    look(pb, 1'b1, 1'b1, "R7");
    res(pb, 1'b1, 32'h0000_0700, 1'b1, "R7");  // 01->11
    look(pb, 1'b0, 1'b1, "R7");
    res(pb, 1'b0, 32'h0, 1'b1, "R8");          // 11->10
    look(pb, 1'b0, 1'b1, "R8");
    res(pb, 1'b0, 32'h0, 1'b1, "R7");          // 10->00
    look(pb, 1'b1, 1'b1, "R7");

    // R10: same-slot lookup during a direction-flipping resolve sees old contents
    res(pd, 1'b1, 32'h0000_0800, 1'b0, "R10"); // alloc 10
    step(pd, 1'b0, 1'b1, pd, 1'b0, 32'h0, 1'b0, "R10"); // predicts taken still
    look(pd, 1'b0, 1'b0, "R10");               // now 01, not taken

    // R9: alias replacement
    look(pc2, 1'b1, 1'b0, "R9");
    res(pc2, 1'b1, 32'h0000_0900, 1'b0, "R9");
    look(pc2, 1'b0, 1'b0, "R9");
    look(pa, 1'b0, 1'b0, "R9");

    // R2: random mix over colliding addresses and both modes
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a1, a2;
      a1 = {14'h0, 2'($urandom_range(0, 3)), 8'h0, 2'($urandom_range(0, 3)), 6'h0};
      a1 = a1 | (32'($urandom_range(0, 3)) << 2);
      a2 = {14'h0, 2'($urandom_range(0, 3)), 8'h0, 2'($urandom_range(0, 3)), 6'h0};
      a2 = a2 | (32'($urandom_range(0, 3)) << 2);
      step(a1, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a2,
           1'($urandom_range(0, 1)), $urandom, 1'($urandom_range(0, 1)), "R2");
    end

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule